// File: doc/BRIEF.md
# Oversampled Dual-Edge Input Capture

This block receives a slow source-synchronous bus. The sender presents a new data word on every transition of its own clock, rising or falling. The block does not use that clock as a clock. A much faster core clock samples the external clock and the data lines together, on the same rising edge, through a bank of synchronizer flops. A copy of the settled clock sample, delayed by one cycle, is compared with the current sample. A mismatch means the external clock changed level. On that cycle the data word that arrived with the new level is registered at the output, a valid flag is raised for one core cycle, and a flag reports whether the transition was rising or falling.

All storage uses the rising edge of the core clock and an active-high synchronous reset. The core clock must run at least four times faster than the external clock. At that ratio each level of the external clock lasts at least two core cycles, so no transition is missed and every valid pulse is isolated.

Top module: `ddr_sampler`

## Requirements
- R1: The external clock and data are sampled together on each core rising edge and pass through SYNC_STAGES register stages. A transition applied before core edge e0 shows on the outputs just after edge e0+SYNC_STAGES, which is SYNC_STAGES+1 edges counting e0.
- R2: While the external clock holds its level, no capture is reported. Data changes alone leave cap_valid low and cap_data unchanged.
- R3: Each external clock transition raises cap_valid for exactly one core cycle.
- R4: Rising and falling transitions of the external clock both produce a capture.
- R5: cap_rise is 1 when the new external clock level is 1 and 0 when it is 0. Because reset clears the sampled level to 0, the first capture after reset is rising and later captures alternate.
- R6: Synchronous reset clears every register. cap_valid and cap_data are 0 during reset, and cap_valid is 0 on the first cycle after reset, whatever level the external clock holds.
- R7: cap_data equals the data word sampled on the same core edge as the new external clock level. It holds that value until the next capture.
- R8: With the external clock at one quarter of the core rate, exactly two captures occur per external period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge only |
| rst | input | 1 | Synchronous reset, active high |
| ext_clk | input | 1 | External slow clock, asynchronous to clk |
| ext_data | input | DATA_W | External data, valid around both edges of ext_clk |
| cap_data | output | DATA_W | Word captured at the last detected transition |
| cap_valid | output | 1 | One-cycle pulse marking a new capture |
| cap_rise | output | 1 | 1 for a rising transition, 0 for a falling one |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and SYNC_STAGES = 2, and derives the expected latency of three core edges from SYNC_STAGES. With an 8-bit word it can drive counting, alternating-bit and nibble-mirrored patterns that differ on every external edge, so a word that is late or early by one transition shows as a mismatch. A four-to-one clock ratio leaves exactly two core cycles per external level. That is the closest spacing the block accepts, so it tests pulse isolation and the two-captures-per-period count at their limit.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;

    // Smallest ratio of core clock to external clock the block accepts.
    localparam int MIN_RATIO = 4;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic      seen;
        edge_pol_e pol;
    } edge_evt_t;

    // Classify a level change between the present and previous samples.
    function automatic edge_evt_t classify(input logic now_lvl, input logic old_lvl);
        edge_evt_t r;
        r.seen = now_lvl ^ old_lvl;
        r.pol  = now_lvl ? EDGE_RISE : EDGE_FALL;
        return r;
    endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/edge_finder.sv
module edge_finder
    import ddrcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    output edge_evt_t evt
);
    logic lvl_d;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= lvl;
    end

    assign evt = classify(lvl, lvl_d);
endmodule

// File: rtl/capture_reg.sv
module capture_reg
    import ddrcap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  edge_evt_t    evt,
    input  logic [W-1:0] word,
    output logic [W-1:0] data,
    output logic         valid,
    output logic         rise
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
            rise  <= 1'b0;
        end else begin
            valid <= evt.seen;
            if (evt.seen) begin
                data <= word;
                rise <= (evt.pol == EDGE_RISE);
            end
        end
    end
endmodule

// File: rtl/ddr_sampler.sv
module ddr_sampler
    import ddrcap_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk,
    input  logic [DATA_W-1:0] ext_data,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_valid,
    output logic              cap_rise
);
    localparam int BUS_W = DATA_W + 1;

    logic [BUS_W-1:0]  smp_bus;
    logic              smp_clk;
    logic [DATA_W-1:0] smp_data;
    edge_evt_t         evt;

    // Clock and data travel as one bus so that both are sampled on the same edge.
    sync_bank #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_clk, ext_data}),
        .q   (smp_bus)
    );

    assign smp_clk  = smp_bus[BUS_W-1];
    assign smp_data = smp_bus[DATA_W-1:0];

    edge_finder u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (smp_clk),
        .evt (evt)
    );

    capture_reg #(.W(DATA_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .word  (smp_data),
        .data  (cap_data),
        .valid (cap_valid),
        .rise  (cap_rise)
    );
endmodule

// File: rtl/ddr_sampler_chk.sv
module ddr_sampler_chk
    import ddrcap_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      smp_clk,
    input edge_evt_t evt,
    input logic      cap_valid,
    input logic      cap_rise
);
    // Polarity expected at the next capture; reset leaves the sampled level at 0.
    logic nxt_rise;
    always_ff @(posedge clk) begin
        if (rst)            nxt_rise <= 1'b1;
        else if (cap_valid) nxt_rise <= ~nxt_rise;
    end

    // R6: no capture on the cycle after a reset cycle
    a_r6_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !cap_valid);

    // R2: a settled clock sample that holds its level produces no capture
    a_r2_stable_no_valid: assert property (@(posedge clk) disable iff (rst)
        $stable(smp_clk) |=> !cap_valid);

    // R4: every detected transition reaches the output on the next cycle
    a_r4_event_to_valid: assert property (@(posedge clk) disable iff (rst)
        evt.seen |=> cap_valid);

    // R5: captures alternate, starting with a rising one
    a_r5_alternating: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> (cap_rise == nxt_rise));

    // R3: pulses stay isolated when the input clock ratio is respected
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> !cap_valid);
endmodule

bind ddr_sampler ddr_sampler_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_clk   (smp_clk),
    .evt       (evt),
    .cap_valid (cap_valid),
    .cap_rise  (cap_rise)
);

// File: tb/sim_ddr_sampler.sv
`timescale 1ns/1ps
module sim_ddr_sampler;
    localparam int DW  = 8;
    localparam int SS  = 2;
    localparam int LAT = SS + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext_clk = 1'b0;
    logic [DW-1:0] ext_data = '0;
    logic [DW-1:0] cap_data;
    logic          cap_valid;
    logic          cap_rise;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] got_data [0:1023];
    logic          got_rise [0:1023];
    int            got_n = 0;
    logic          prev_v = 1'b0;

    logic [DW-1:0] exp_data [0:127];
    logic          exp_rise [0:127];

    ddr_sampler #(.DATA_W(DW), .SYNC_STAGES(SS)) u0 (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .ext_data(ext_data),
        .cap_data(cap_data), .cap_valid(cap_valid), .cap_rise(cap_rise)
    );

    always #2.5 clk = ~clk;

    // Record captures away from the active edge; R3 pulse width watched here.
    always @(negedge clk) begin
        if (!rst && cap_valid) begin
            if (got_n < 1024) begin
                got_data[got_n] = cap_data;
                got_rise[got_n] = cap_rise;
            end
            got_n++;
            checks++;
            if (prev_v) begin
                errors++;
                $display("FAIL R3 valid high two cycles: act=1 exp=0");
            end
        end
        prev_v = !rst && cap_valid;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat_word(input int pat, input int i);
        logic [3:0] n;
        n = i[3:0];
        case (pat)
            0:       return DW'(i * 17 + 3);
            1:       return i[0] ? 8'hAA : 8'h55;
            default: return {n, ~n};
        endcase
    endfunction

    task automatic t_reset_low();
        rst = 1'b1; ext_clk = 1'b0; ext_data = 8'hC3;
        repeat (3) @(negedge clk);
        chk(cap_valid == 1'b0, "R6", "valid in reset", cap_valid, 0);
        chk(cap_data == '0, "R6", "data in reset", cap_data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cap_valid == 1'b0, "R6", "valid first cycle", cap_valid, 0);
        repeat (LAT + 2) @(negedge clk);
        chk(got_n == 0, "R2", "captures with idle clock", got_n, 0);
    endtask

    task automatic t_latency();
        int base;
        base = got_n;
        @(negedge clk);
        ext_clk = 1'b1; ext_data = 8'h3C;
        for (int c = 1; c <= LAT + 1; c++) begin
            @(negedge clk);
            if (c == LAT) begin
                chk(cap_valid == 1'b1, "R1", "valid at latency", cap_valid, 1);
                chk(cap_data == 8'h3C, "R7", "latency word", cap_data, 8'h3C);
                chk(cap_rise == 1'b1, "R5", "rise flag", cap_rise, 1);
            end else begin
                chk(cap_valid == 1'b0, "R3", "valid off-cycle", cap_valid, 0);
            end
        end
        ext_clk = 1'b0; ext_data = 8'hE1;
        repeat (LAT + 2) @(negedge clk);
        chk(got_n - base == 2, "R4", "rise and fall captured", got_n - base, 2);
        if (got_n - base == 2) begin
            chk(got_rise[base + 1] == 1'b0, "R4", "fall polarity", got_rise[base + 1], 0);
            chk(got_data[base + 1] == 8'hE1, "R7", "fall word", got_data[base + 1], 8'hE1);
        end
    endtask

    task automatic t_stream(input int pat, input int periods);
        int base;
        int n;
        base = got_n;
        n = 0;
        for (int i = 0; i < 2 * periods; i++) begin
            @(negedge clk);
            ext_clk = ~ext_clk;
            ext_data = pat_word(pat, i);
            exp_data[n] = ext_data;
            exp_rise[n] = ext_clk;
            n++;
            @(negedge clk);
        end
        repeat (LAT + 2) @(negedge clk);
        chk(got_n - base == 2 * periods, "R8", "captures per stream", got_n - base, 2 * periods);
        if (got_n - base == 2 * periods) begin
            for (int k = 0; k < n; k++) begin
                chk(got_data[base + k] == exp_data[k], "R7", "stream word",
                    got_data[base + k], exp_data[k]);
                chk(got_rise[base + k] == exp_rise[k], "R5", "stream polarity",
                    got_rise[base + k], exp_rise[k]);
            end
        end
    endtask

    task automatic t_data_only();
        int base;
        logic [DW-1:0] held;
        base = got_n;
        held = cap_data;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ext_data = DW'(i * 37 + 5);
            chk(cap_valid == 1'b0, "R2", "valid on data-only change", cap_valid, 0);
        end
        repeat (LAT + 2) @(negedge clk);
        chk(cap_valid == 1'b0, "R2", "valid after data-only", cap_valid, 0);
        chk(cap_data == held, "R2", "word held", cap_data, held);
        chk(got_n == base, "R2", "no capture", got_n - base, 0);
    endtask

    task automatic t_reset_high();
        int base;
        @(negedge clk);
        rst = 1'b1; ext_clk = 1'b1; ext_data = 8'h5A;
        repeat (3) @(negedge clk);
        chk(cap_valid == 1'b0, "R6", "valid in reset (clk high)", cap_valid, 0);
        chk(cap_data == '0, "R6", "data cleared", cap_data, 0);
        base = got_n;
        rst = 1'b0;
        @(negedge clk);
        chk(cap_valid == 1'b0, "R6", "first cycle after reset", cap_valid, 0);
        repeat (LAT + 2) @(negedge clk);
        chk(got_n - base == 1, "R5", "one capture after reset", got_n - base, 1);
        if (got_n - base == 1) begin
            chk(got_rise[base] == 1'b1, "R5", "first capture rising", got_rise[base], 1);
            chk(got_data[base] == 8'h5A, "R7", "first capture word", got_data[base], 8'h5A);
        end
        @(negedge clk);
        ext_clk = 1'b0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: act=timeout exp=finished");
        finish_run();
    end

    initial begin
        t_reset_low();
        t_latency();
        t_stream(0, 16);
        t_data_only();
        t_stream(1, 12);
        t_stream(2, 16);
        t_reset_high();
        t_stream(0, 4);
        finish_run();
    end
endmodule